// File: doc/BRIEF.md
# Framed Binary FSK Sample Generator

This block turns a stream of data bits into a signed 16-bit binary FSK sample stream for a 48 kHz sample clock. The sample clock reaches it as a one-cycle strobe, and each strobe produces exactly one output sample. A 0 bit is sent as a 1200 Hz tone (40 samples per cycle). A 1 bit is sent as a 2400 Hz tone (20 samples per cycle). Every bit lasts 80 samples, so each bit holds a whole number of tone cycles: two for a 0 and four for a 1.

Bits arrive through a valid/ready handshake and are gathered into groups of 17. A group goes out only once all 17 bits are held. It is sent as one frame: first one slot of 80 samples carrying a synchronisation impulse, then the 17 data bits, 1440 samples in all. While a frame is being sent, the next 17 bits are gathered, so frames can follow one another with no gap. When no full group is waiting, the output is silence: zero samples that still carry the valid flag.

The tone values come from a precomputed table that holds one 40-entry cosine period. The table is stored as a quarter wave and the rest is folded out by symmetry. Two markers are driven alongside each sample: one flags the start of a frame and the other flags the start of each data bit. A downstream framer or converter uses these markers to line up with the stream.

Top module: `fskm_frame_mod`

## Requirements
- R1: While reset is held, `out_valid`, `frame_start` and `bit_start` are 0, `out_sample` is 0, and `bit_ready` is 1.
- R2: `out_valid` is 1 in the cycle after each cycle with `smp_en` high, and only then. `out_sample` keeps its value in cycles that follow no strobe.
- R3: A bit is taken on a rising edge where `bit_valid` and `bit_ready` are both 1. `bit_ready` is 1 while fewer than 17 bits are held and 0 once 17 are held. Bits go on air in the order they were taken.
- R4: When no 17-bit group is complete at a strobe that could start a frame, that strobe yields the sample 0, with `frame_start` and `bit_start` both 0.
- R5: A frame opens with the sample +32767 and `frame_start` = 1. The next 79 samples are 0, and no marker is set on them.
- R6: Each data bit spans 80 samples, and `bit_start` = 1 on its first sample. Sample n (0..79) of a bit equals round(30000*cos(2*pi*i/40)), where i = n mod 40 for a 0 bit and i = 2n mod 40 for a 1 bit. The phase starts again at 0 with every bit.
- R7: A frame is the sync slot followed by 17 data bits, 1440 samples in all. If another 17 bits are held when a frame ends, the next frame opens on the very next strobe.
- R8: Every tone sample lies within -30000..+30000.
- R9: `bit_in` is ignored in cycles where `bit_ready` is 0, even with `bit_valid` high.
- R10: Once a frame has started, `bit_ready` returns to 1, so the following group is gathered while the current frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample strobe; one output sample per high cycle |
| bit_in | input | 1 | Data bit offered |
| bit_valid | input | 1 | `bit_in` holds a bit to be taken |
| bit_ready | output | 1 | Block can take a bit this cycle |
| out_sample | output | 16 | Signed two's-complement output sample |
| out_valid | output | 1 | `out_sample` was produced by the previous strobe |
| frame_start | output | 1 | Current sample is the sync impulse opening a frame |
| bit_start | output | 1 | Current sample is the first of a data bit |

## Verification
The assertions assume that the outputs are observed only through `out_valid`, and that the strobe is a plain level that may be high in any cycle, including several cycles in a row. They also assume that a source holds `bit_valid` and `bit_in` until the bit is taken. The stimulus gates the strobe with a fixed-seed random coin so that the spacing between samples varies. It pushes bits through a task that keeps them steady until acceptance, and offers bits while `bit_ready` is low only in a directed step that checks those bits are dropped.

// File: rtl/fskm_pkg.sv
package fskm_pkg;

    localparam int SMP_W     = 16;
    localparam int TABLE_LEN = 40;
    localparam int QTR_LEN   = TABLE_LEN / 4;
    localparam int TONE_AMPL = 30000;

    typedef logic signed [SMP_W-1:0] smp_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SYNC,
        SQ_DATA
    } seq_mode_e;

    typedef enum logic [1:0] {
        EMIT_ZERO,
        EMIT_SYNC,
        EMIT_TONE
    } emit_e;

    typedef struct packed {
        smp_t value;
        logic frm;
        logic bst;
    } out_word_t;

    // quarter-wave cosine, entry r = round(TONE_AMPL * cos(2*pi*r/TABLE_LEN))
    function automatic smp_t qcos(input int r);
        case (r)
            0:       return 16'sd30000;
            1:       return 16'sd29631;
            2:       return 16'sd28532;
            3:       return 16'sd26730;
            4:       return 16'sd24271;
            5:       return 16'sd21213;
            6:       return 16'sd17634;
            7:       return 16'sd13620;
            8:       return 16'sd9271;
            9:       return 16'sd4693;
            default: return 16'sd0;
        endcase
    endfunction

endpackage

// File: rtl/fskm_bit_collector.sv
module fskm_bit_collector #(
    parameter int N_BITS = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_bit,
    output logic              in_ready,
    input  logic              take,
    output logic              full,
    output logic [N_BITS-1:0] group_bits
);
    localparam int CW = $clog2(N_BITS + 1);

    logic [CW-1:0]     cnt;
    logic [N_BITS-1:0] sreg;
    logic              accept;

    assign full       = (cnt == CW'(N_BITS));
    assign in_ready   = !full;
    assign accept     = in_valid && in_ready;
    assign group_bits = sreg;

    // first bit taken ends at position 0 once the group is full
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            sreg <= '0;
        end else if (take) begin
            cnt <= '0;
        end else if (accept) begin
            sreg <= {in_bit, sreg[N_BITS-1:1]};
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fskm_tone_rom.sv
module fskm_tone_rom
    import fskm_pkg::*;
#(
    parameter int PH_W = 6
) (
    input  logic [PH_W-1:0] phase,
    output smp_t            value
);
    int p;
    int quad;
    int rem;

    always_comb begin
        p    = int'(phase);
        quad = p / QTR_LEN;
        rem  = p % QTR_LEN;
        case (quad)
            0:       value = qcos(rem);
            1:       value = -qcos(QTR_LEN - rem);
            2:       value = -qcos(rem);
            default: value = qcos(QTR_LEN - rem);
        endcase
    end

endmodule

// File: rtl/fskm_sequencer.sv
module fskm_sequencer
    import fskm_pkg::*;
#(
    parameter int BITS = 17,
    parameter int SPB  = 80,
    parameter int SLOW = 1,
    parameter int FAST = 2,
    parameter int TLEN = 40
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          strobe,
    input  logic                          coll_full,
    input  logic [BITS-1:0]               coll_bits,
    output logic                          take,
    output emit_e                         emit,
    output logic [$clog2(TLEN)-1:0]       phase,
    output logic                          frame_mark,
    output logic                          bit_mark
);
    localparam int CNT_W  = $clog2(SPB);
    localparam int BIDX_W = $clog2(BITS);
    localparam int PH_W   = $clog2(TLEN);
    localparam logic [PH_W:0] TLEN_X = (PH_W+1)'(TLEN);

    seq_mode_e         mode;
    logic [CNT_W-1:0]  scnt;
    logic [BIDX_W-1:0] bidx;
    logic [PH_W-1:0]   ph;
    logic [BITS-1:0]   fbits;

    logic              launch;
    logic              slot_end;
    logic              last_bit;
    logic [PH_W-1:0]   step;
    logic [PH_W:0]     ph_sum;
    logic [PH_W:0]     ph_next;

    assign launch   = strobe && (mode == SQ_IDLE) && coll_full;
    assign slot_end = (scnt == CNT_W'(SPB - 1));
    assign last_bit = (bidx == BIDX_W'(BITS - 1));
    assign step     = fbits[0] ? PH_W'(FAST) : PH_W'(SLOW);
    assign ph_sum   = {1'b0, ph} + {1'b0, step};
    assign ph_next  = (ph_sum >= TLEN_X) ? (ph_sum - TLEN_X) : ph_sum;

    assign take       = launch;
    assign frame_mark = launch;
    assign bit_mark   = (mode == SQ_DATA) && (scnt == '0);
    assign phase      = ph;

    always_comb begin
        if (mode == SQ_DATA)
            emit = EMIT_TONE;
        else if (launch)
            emit = EMIT_SYNC;
        else
            emit = EMIT_ZERO;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= SQ_IDLE;
            scnt  <= '0;
            bidx  <= '0;
            ph    <= '0;
            fbits <= '0;
        end else if (strobe) begin
            case (mode)
                SQ_IDLE: begin
                    if (coll_full) begin
                        mode  <= SQ_SYNC;
                        scnt  <= CNT_W'(1);
                        fbits <= coll_bits;
                    end
                end
                SQ_SYNC: begin
                    if (slot_end) begin
                        mode <= SQ_DATA;
                        scnt <= '0;
                        bidx <= '0;
                        ph   <= '0;
                    end else begin
                        scnt <= scnt + 1'b1;
                    end
                end
                default: begin
                    if (slot_end) begin
                        scnt  <= '0;
                        ph    <= '0;
                        fbits <= fbits >> 1;
                        if (last_bit)
                            mode <= SQ_IDLE;
                        else
                            bidx <= bidx + 1'b1;
                    end else begin
                        scnt <= scnt + 1'b1;
                        ph   <= ph_next[PH_W-1:0];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/fskm_frame_mod.sv
module fskm_frame_mod
    import fskm_pkg::*;
#(
    parameter int BITS_PER_FRAME  = 17,
    parameter int SAMPLES_PER_BIT = 80,
    parameter int SLOW_STEP       = 1,
    parameter int FAST_STEP       = 2,
    parameter int SYNC_LEVEL      = 32767
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_en,
    input  logic        bit_in,
    input  logic        bit_valid,
    output logic        bit_ready,
    output logic [15:0] out_sample,
    output logic        out_valid,
    output logic        frame_start,
    output logic        bit_start
);
    localparam int PH_W = $clog2(TABLE_LEN);

    logic                      coll_full;
    logic [BITS_PER_FRAME-1:0] coll_bits;
    logic                      take;
    emit_e                     emit;
    logic [PH_W-1:0]           phase;
    logic                      frame_mark;
    logic                      bit_mark;
    smp_t                      tone_val;
    out_word_t                 next_word;
    out_word_t                 out_q;
    logic                      valid_q;

    fskm_bit_collector #(
        .N_BITS(BITS_PER_FRAME)
    ) u_collect (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (bit_valid),
        .in_bit    (bit_in),
        .in_ready  (bit_ready),
        .take      (take),
        .full      (coll_full),
        .group_bits(coll_bits)
    );

    fskm_sequencer #(
        .BITS(BITS_PER_FRAME),
        .SPB (SAMPLES_PER_BIT),
        .SLOW(SLOW_STEP),
        .FAST(FAST_STEP),
        .TLEN(TABLE_LEN)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .strobe    (smp_en),
        .coll_full (coll_full),
        .coll_bits (coll_bits),
        .take      (take),
        .emit      (emit),
        .phase     (phase),
        .frame_mark(frame_mark),
        .bit_mark  (bit_mark)
    );

    fskm_tone_rom #(
        .PH_W(PH_W)
    ) u_rom (
        .phase(phase),
        .value(tone_val)
    );

    always_comb begin
        case (emit)
            EMIT_TONE: next_word.value = tone_val;
            EMIT_SYNC: next_word.value = smp_t'(SYNC_LEVEL);
            default:   next_word.value = '0;
        endcase
        next_word.frm = frame_mark;
        next_word.bst = bit_mark;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            valid_q <= 1'b0;
        end else if (smp_en) begin
            out_q   <= next_word;
            valid_q <= 1'b1;
        end else begin
            out_q.frm <= 1'b0;
            out_q.bst <= 1'b0;
            valid_q   <= 1'b0;
        end
    end

    assign out_sample  = out_q.value;
    assign out_valid   = valid_q;
    assign frame_start = out_q.frm;
    assign bit_start   = out_q.bst;

endmodule

// File: rtl/fskm_checker.sv
module fskm_checker #(
    parameter int BITS       = 17,
    parameter int SPB        = 80,
    parameter int SYNC_LEVEL = 32767,
    parameter int AMPL       = 30000
) (
    input logic        clk,
    input logic        rst,
    input logic        smp_en,
    input logic        bit_ready,
    input logic [15:0] out_sample,
    input logic        out_valid,
    input logic        frame_start,
    input logic        bit_start
);
    localparam int FRAME_SMP = (BITS + 1) * SPB;
    localparam int PW        = $clog2(FRAME_SMP + 1);

    logic [PW-1:0] pos;
    int            spos;

    assign spos = int'($signed(out_sample));

    // count of samples of the current frame already presented
    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (out_valid) begin
            if (frame_start)
                pos <= PW'(1);
            else if (pos == PW'(FRAME_SMP - 1))
                pos <= '0;
            else if (pos != '0)
                pos <= pos + 1'b1;
        end
    end

    AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(smp_en))); // R2
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(smp_en)) |-> $stable(out_sample)); // R2
    AST_LAUNCH_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !$past(bit_ready)); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pos == '0 && !frame_start) |-> (spos == 0 && !bit_start)); // R4
    AST_SYNC_LEVEL: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (out_valid && spos == SYNC_LEVEL && !bit_start)); // R5
    AST_SYNC_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pos != '0 && int'(pos) < SPB) |-> (spos == 0 && !bit_start)); // R5
    AST_BIT_GRID: assert property (@(posedge clk) disable iff (rst)
        bit_start |-> (out_valid && int'(pos) >= SPB && (int'(pos) % SPB) == 0)); // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (pos == '0)); // R7
    AST_TONE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (out_valid && int'(pos) >= SPB) |-> (spos <= AMPL && spos >= -AMPL)); // R8

endmodule

bind fskm_frame_mod fskm_checker #(
    .BITS      (BITS_PER_FRAME),
    .SPB       (SAMPLES_PER_BIT),
    .SYNC_LEVEL(SYNC_LEVEL),
    .AMPL      (fskm_pkg::TONE_AMPL)
) u_fskm_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_en     (smp_en),
    .bit_ready  (bit_ready),
    .out_sample (out_sample),
    .out_valid  (out_valid),
    .frame_start(frame_start),
    .bit_start  (bit_start)
);

// File: tb/tb_fskm_frame_mod.sv
module tb_fskm_frame_mod;

    localparam int NB   = 17;
    localparam int SPB  = 80;
    localparam int FSMP = (NB + 1) * SPB;

    typedef struct {
        int val;
        bit fs;
        bit bs;
        int kind;     // 0 idle, 1 sync slot, 2 data
        int frame_no;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        smp_en;
    logic        bit_in;
    logic        bit_valid;
    logic        bit_ready;
    logic [15:0] out_sample;
    logic        out_valid;
    logic        frame_start;
    logic        bit_start;

    int checks = 0;
    int errors = 0;
    bit strobe_on = 1'b0;
    bit strobe_last = 1'b0;
    bit pend[$];
    exp_t expq[$];
    bit fb[NB];
    bit busy = 1'b0;
    bit ended_prev = 1'b0;
    int k = 0;
    int frames = 0;
    int b2b = 0;
    logic [15:0] prev_sample = '0;

    fskm_frame_mod dut (
        .clk        (clk),
        .rst        (rst),
        .smp_en     (smp_en),
        .bit_in     (bit_in),
        .bit_valid  (bit_valid),
        .bit_ready  (bit_ready),
        .out_sample (out_sample),
        .out_valid  (out_valid),
        .frame_start(frame_start),
        .bit_start  (bit_start)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int tone_ref(input int n, input bit b);
        int  idx;
        real r;
        idx = (n * (b ? 2 : 1)) % 40;
        r   = 30000.0 * $cos(2.0 * 3.14159265358979 * idx / 40.0);
        return $rtoi(r + ((r >= 0.0) ? 0.5 : -0.5));
    endfunction

    task automatic model_step();
        exp_t e;
        int   n;
        if (!busy && pend.size() >= NB) begin
            for (int i = 0; i < NB; i++) fb[i] = pend.pop_front();
            busy = 1'b1;
            k = 0;
            frames++;
            if (ended_prev) b2b++;
        end
        ended_prev = 1'b0;
        e.frame_no = frames;
        e.fs = 1'b0;
        e.bs = 1'b0;
        if (!busy) begin
            e.val = 0; e.kind = 0;
        end else begin
            if (k == 0) begin
                e.val = 32767; e.fs = 1'b1; e.kind = 1;
            end else if (k < SPB) begin
                e.val = 0; e.kind = 1;
            end else begin
                n = (k - SPB) % SPB;
                e.val = tone_ref(n, fb[(k - SPB) / SPB]);
                e.bs = (n == 0);
                e.kind = 2;
            end
            k++;
            if (k == FSMP) begin
                busy = 1'b0;
                ended_prev = 1'b1;
            end
        end
        expq.push_back(e);
    endtask

    // reference model: reads pre-edge values of inputs and bit_ready
    always @(posedge clk) begin
        if (rst) begin
            strobe_last = 1'b0;
        end else begin
            strobe_last = smp_en;
            if (smp_en) model_step();
            if (bit_valid && bit_ready) pend.push_back(bit_in);
        end
    end

    // output monitor, away from the active edge
    always @(negedge clk) begin
        exp_t e;
        int   act;
        int   diff;
        if (!rst) begin
            check(out_valid == strobe_last, "R2 out_valid vs strobe", out_valid, strobe_last);
            if (!strobe_last)
                check(out_sample == prev_sample, "R2 sample hold", out_sample, prev_sample);
            if (out_valid && expq.size() > 0) begin
                e = expq.pop_front();
                act = int'($signed(out_sample));
                if (e.kind == 2) begin
                    diff = act - e.val;
                    if (diff < 0) diff = -diff;
                    check(diff <= 1, (e.frame_no == 1) ? "R9 R6 tone sample" : "R6 tone sample", act, e.val);
                    check(act <= 30000 && act >= -30000, "R8 tone bound", act, 30000);
                end else if (e.kind == 1) begin
                    check(act == e.val, "R5 sync slot sample", act, e.val);
                end else begin
                    check(act == e.val, "R4 idle sample", act, e.val);
                end
                check(frame_start == e.fs, "R7 frame_start marker", frame_start, e.fs);
                check(bit_start == e.bs, "R6 bit_start marker", bit_start, e.bs);
            end
            prev_sample = out_sample;
        end
    end

    // sample strobe generator
    initial begin
        smp_en = 1'b0;
        forever begin
            @(negedge clk);
            smp_en <= strobe_on && (($urandom % 2) == 0);
        end
    end

    task automatic push_bit(input bit b, input int gap);
        repeat (gap) @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        while (!bit_ready) @(negedge clk);
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit pat[NB];
        pat = '{0, 1, 1, 0, 0, 0, 1, 1, 1, 1, 0, 1, 0, 0, 1, 0, 1};
        void'($urandom(32'd4242));
        rst = 1'b1;
        bit_valid = 1'b0;
        bit_in = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state under reset
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(out_sample == 16'd0, "R1 out_sample in reset", out_sample, 0);
        check(frame_start == 1'b0 && bit_start == 1'b0, "R1 markers in reset", frame_start, 0);
        check(bit_ready == 1'b1, "R1 bit_ready in reset", bit_ready, 1);
        rst = 1'b0;

        // R4: silence with no bits held
        strobe_on = 1'b1;
        repeat (300) @(negedge clk);

        // R3: gather a directed group with the strobe stopped
        strobe_on = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NB - 1; i++) push_bit(pat[i], i % 3);
        check(bit_ready == 1'b1, "R3 ready with 16 held", bit_ready, 1);
        push_bit(pat[NB-1], 0);
        check(bit_ready == 1'b0, "R3 ready with 17 held", bit_ready, 0);

        // R9: bits offered while not ready are dropped
        bit_valid = 1'b1;
        bit_in = 1'b1;
        repeat (8) @(negedge clk);
        check(bit_ready == 1'b0, "R9 ready stays low while offered", bit_ready, 0);
        bit_valid = 1'b0;
        check(pend.size() == NB, "R9 bench accepted count", pend.size(), NB);

        // R10: ready returns once the frame has started
        strobe_on = 1'b1;
        while (!frame_start) @(negedge clk);
        repeat (3) @(negedge clk);
        check(bit_ready == 1'b1, "R10 ready after launch", bit_ready, 1);

        // random bit stream, fast enough to keep frames back to back
        for (int i = 0; i < 3 * NB; i++) push_bit(1'($urandom % 2), int'($urandom % 4));
        while (busy || pend.size() != 0) @(negedge clk);

        // R4: starved source, only part of a group held
        for (int i = 0; i < 10; i++) push_bit(1'($urandom % 2), int'($urandom % 3));
        repeat (1500) @(negedge clk);
        check(frames == 4, "R4 no launch on partial group", frames, 4);
        for (int i = 0; i < NB - 10; i++) push_bit(1'($urandom % 2), 0);
        while (busy || pend.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);

        // R7: frame count and gapless succession
        check(frames == 5, "R7 frames sent", frames, 5);
        check(b2b >= 1, "R7 back-to-back frames seen", b2b, 1);
        check(expq.size() == 0, "R2 every strobe gave a sample", expq.size(), 0);
        finish_run();
    end

endmodule